// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Controller

This block drives the fetch address and the squash of the fetch/decode register in a five-stage in-order pipeline whose conditional branches are settled in decode. Decode holds both the two-register equality/inequality compare and the target adder. A taken branch therefore costs at most one cycle, where resolving it later in the pipeline would cost three.

A 2-bit selector chooses how the controller treats the instruction fetched behind a branch. The four choices are: wait for the outcome, assume fall-through, assume taken, or execute one delay slot. The block also detects when a branch operand is still being produced by a nearby older instruction. It then freezes fetch and decode until forwarding can supply the value.

The pipeline applies `next_pc` at the next fetch edge. It clears the IF/ID valid bit when `ifid_flush` is high, and holds both the PC and IF/ID when `fetch_hold` is high.

Top module: `brres_ctrl`

## Requirements
- R1: When `id_branch` is low, `next_pc` is `if_pc`+4 and `ifid_flush` and `fetch_hold` are both low. This holds whatever the hazard inputs carry, and it is also the state during and straight after reset.
- R2: The branch target is `id_pc`+4+(`imm_ext` shifted left by two). Negative offsets follow two's-complement wrap. With `id_br_ne`=0 the branch is taken when `rs_val`==`rt_val`; with `id_br_ne`=1 it is taken when they differ.
- R3: Policy code 0 (wait) squashes IF/ID on every resolved branch. `next_pc` is the target when taken, else `id_pc`+4.
- R4: Policy code 1 (assume fall-through) leaves IF/ID intact and sends `next_pc`=`if_pc`+4 on a not-taken branch. On a taken branch it squashes IF/ID and sends the target.
- R5: Policy code 2 (assume taken) squashes IF/ID on every resolved branch, because the target only exists in decode. `next_pc` is the target when taken, else `id_pc`+4.
- R6: Policy code 3 (delay slot) never squashes. `next_pc` is the target when taken, else `if_pc`+4, so the instruction already in fetch always runs.
- R7: A branch whose `id_rs` or `id_rt` equals `ex_rd` while `ex_wr_en` is high raises `fetch_hold`, keeps `ifid_flush` low and gives `next_pc`=`if_pc`.
- R8: A branch whose `id_rs` or `id_rt` equals `mem_rd` while `mem_ld` is high stalls exactly as in R7.
- R9: Register number 0 never causes a stall.
- R10: The policy is captured on a clock edge only when no branch is in decode. It takes effect on the following cycle. A change of `policy_sel` while a branch sits in decode, stalled or not, does not alter how that branch is handled.
- R11: `ifid_flush` and `fetch_hold` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 2 | Branch policy code (0 wait, 1 fall-through, 2 taken, 3 delay slot) |
| id_branch | input | 1 | Valid conditional branch in decode |
| id_br_ne | input | 1 | 0 = branch on equal, 1 = branch on not equal |
| id_rs | input | 5 | First source register number of the branch |
| id_rt | input | 5 | Second source register number of the branch |
| rs_val | input | 32 | First operand value |
| rt_val | input | 32 | Second operand value |
| imm_ext | input | 32 | Sign-extended word offset |
| id_pc | input | 32 | Address of the branch |
| if_pc | input | 32 | Address of the instruction being fetched |
| ex_wr_en | input | 1 | Instruction in execute writes a register |
| ex_rd | input | 5 | Destination register in execute |
| mem_ld | input | 1 | Instruction in memory stage is a load |
| mem_rd | input | 5 | Destination register in memory stage |
| next_pc | output | 32 | Address to fetch next |
| ifid_flush | output | 1 | Clear the IF/ID valid bit |
| fetch_hold | output | 1 | Hold PC and IF/ID this cycle |

## Verification
The bench drives each policy with both outcomes and both compare senses, including a backward offset. Each case has its own expected redirect and squash. A controller that mixed up the policy codes would flush a delay slot or keep a wrong-path fetch. One that used `if_pc` where `id_pc` belongs would land one word off on fall-through.

Operand hazards from execute and from a load in memory are checked apart from each other, together with a register-0 writer. Getting these wrong would either redirect on a stale operand or stall forever on the zero register.

A directed sequence changes the selector while a branch is held by a hazard. A design that samples the policy during a branch would switch the handling of that branch part-way through.

// File: rtl/brres_pkg.sv
package brres_pkg;
  localparam int XLEN = 32;
  localparam int REGW = 5;

  typedef enum logic [1:0] {
    POL_WAIT  = 2'd0,
    POL_FALL  = 2'd1,
    POL_TAKEN = 2'd2,
    POL_SLOT  = 2'd3
  } br_policy_e;
endpackage

// File: rtl/brres_cmp_tgt.sv
module brres_cmp_tgt #(
  parameter int W = 32
) (
  input  logic         br_ne,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] pc,
  output logic         taken,
  output logic [W-1:0] target,
  output logic [W-1:0] fall
);
  localparam logic [W-1:0] WORD = W'(4);

  logic same;

  always_comb begin
    same   = (opa == opb);
    taken  = br_ne ? !same : same;
    fall   = pc + WORD;
    target = fall + (imm << 2);
  end
endmodule

// File: rtl/brres_hazard.sv
module brres_hazard #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk,
  input  logic [RW-1:0] rs,
  input  logic [RW-1:0] rt,
  input  logic          ex_wr,
  input  logic [RW-1:0] ex_rd,
  input  logic          mem_ld,
  input  logic [RW-1:0] mem_rd,
  output logic          stall
);
  logic ex_hit, mem_hit;

  always_comb begin
    ex_hit  = ex_wr  && (ex_rd  != '0) && ((ex_rd  == rs) || (ex_rd  == rt));
    mem_hit = mem_ld && (mem_rd != '0) && ((mem_rd == rs) || (mem_rd == rt));
    stall   = chk && (ex_hit || mem_hit);
  end

  AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0 && mem_rd == '0) |-> !stall); // R9
  AST_NO_CHECK_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !chk |-> !stall); // R1
endmodule

// File: rtl/brres_policy_reg.sv
module brres_policy_reg
  import brres_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic [1:0] sel,
  output br_policy_e pol_q
);
  br_policy_e pol_d;
  logic       load_en;

  always_comb begin
    load_en = !busy;
    pol_d   = br_policy_e'(sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pol_q <= POL_WAIT;
    else if (load_en) pol_q <= pol_d;
  end

  AST_POLICY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pol_q)); // R10
endmodule

// File: rtl/brres_ctrl.sv
module brres_ctrl
  import brres_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int RW = REGW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    policy_sel,
  input  logic          id_branch,
  input  logic          id_br_ne,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic [W-1:0]  rs_val,
  input  logic [W-1:0]  rt_val,
  input  logic [W-1:0]  imm_ext,
  input  logic [W-1:0]  id_pc,
  input  logic [W-1:0]  if_pc,
  input  logic          ex_wr_en,
  input  logic [RW-1:0] ex_rd,
  input  logic          mem_ld,
  input  logic [RW-1:0] mem_rd,
  output logic [W-1:0]  next_pc,
  output logic          ifid_flush,
  output logic          fetch_hold
);
  localparam logic [W-1:0] WORD = W'(4);

  br_policy_e pol;
  logic       taken, stall, resolved;
  logic [W-1:0] target, fall, seq_pc, redirect;

  brres_cmp_tgt #(.W(W)) u_cmp (
    .br_ne(id_br_ne), .opa(rs_val), .opb(rt_val), .imm(imm_ext),
    .pc(id_pc), .taken(taken), .target(target), .fall(fall)
  );

  brres_hazard #(.RW(RW)) u_haz (
    .clk(clk), .rst_n(rst_n), .chk(id_branch), .rs(id_rs), .rt(id_rt),
    .ex_wr(ex_wr_en), .ex_rd(ex_rd), .mem_ld(mem_ld), .mem_rd(mem_rd),
    .stall(stall)
  );

  brres_policy_reg u_pol (
    .clk(clk), .rst_n(rst_n), .busy(id_branch), .sel(policy_sel), .pol_q(pol)
  );

  always_comb begin
    seq_pc     = if_pc + WORD;
    resolved   = id_branch && !stall;
    redirect   = taken ? target : fall;
    next_pc    = seq_pc;
    ifid_flush = 1'b0;
    fetch_hold = 1'b0;
    if (stall) begin
      fetch_hold = 1'b1;
      next_pc    = if_pc;
    end else if (resolved) begin
      unique case (pol)
        POL_WAIT, POL_TAKEN: begin
          ifid_flush = 1'b1;
          next_pc    = redirect;
        end
        POL_FALL: begin
          ifid_flush = taken;
          next_pc    = taken ? target : seq_pc;
        end
        POL_SLOT: begin
          next_pc    = taken ? target : seq_pc;
        end
        default: next_pc = seq_pc;
      endcase
    end
  end

  AST_FLUSH_HOLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifid_flush && fetch_hold)); // R11
  AST_SLOT_NEVER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_SLOT) |-> !ifid_flush); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !id_branch |-> (!ifid_flush && !fetch_hold && next_pc == if_pc + WORD)); // R1
  AST_HOLD_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hold |-> (next_pc == if_pc)); // R7
  AST_FALL_NT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_FALL && id_branch && !fetch_hold && next_pc == if_pc + WORD
     && next_pc != target) |-> !ifid_flush); // R4
endmodule

// File: tb/brres_ctrl_tb.sv
`timescale 1ns/1ps
module brres_ctrl_tb;
  logic        clk, rst_n;
  logic [1:0]  policy_sel;
  logic        id_branch, id_br_ne, ex_wr_en, mem_ld;
  logic [4:0]  id_rs, id_rt, ex_rd, mem_rd;
  logic [31:0] rs_val, rt_val, imm_ext, id_pc, if_pc, next_pc;
  logic        ifid_flush, fetch_hold;
  int          n_chk, n_fail;

  brres_ctrl u_dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [1:0]  pol;
    logic        br;
    logic        ne;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] off;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic        exw;
    logic [4:0]  exd;
    logic        mld;
    logic [4:0]  mdd;
    logic [31:0] npc;
    logic        fl;
    logic        hd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam logic [31:0] NEG2 = 32'hFFFF_FFFE;
  // id_pc = 0x100, if_pc = 0x104 for every vector
  localparam vec_t VEC [NV] = '{
    '{2'd0,1'b1,1'b0,32'd5,32'd5,32'd4,5'd1,5'd2,1'b0,5'd0,1'b0,5'd0,32'h114,1'b1,1'b0,8'd3},  // R3 taken
    '{2'd0,1'b1,1'b0,32'd5,32'd6,32'd4,5'd1,5'd2,1'b0,5'd0,1'b0,5'd0,32'h104,1'b1,1'b0,8'd3},  // R3 not taken
    '{2'd1,1'b1,1'b0,32'd5,32'd5,32'd4,5'd1,5'd2,1'b0,5'd0,1'b0,5'd0,32'h114,1'b1,1'b0,8'd4},  // R4 taken
    '{2'd1,1'b1,1'b1,32'd5,32'd5,32'd4,5'd1,5'd2,1'b0,5'd0,1'b0,5'd0,32'h108,1'b0,1'b0,8'd4},  // R4 not taken
    '{2'd2,1'b1,1'b1,32'd5,32'd6,32'd4,5'd1,5'd2,1'b0,5'd0,1'b0,5'd0,32'h114,1'b1,1'b0,8'd5},  // R5 taken
    '{2'd2,1'b1,1'b0,32'd5,32'd6,32'd4,5'd1,5'd2,1'b0,5'd0,1'b0,5'd0,32'h104,1'b1,1'b0,8'd5},  // R5 not taken
    '{2'd3,1'b1,1'b0,32'd7,32'd7,NEG2, 5'd1,5'd2,1'b0,5'd0,1'b0,5'd0,32'h0FC,1'b0,1'b0,8'd6},  // R6 taken, R2 backward
    '{2'd3,1'b1,1'b1,32'd7,32'd7,32'd4,5'd1,5'd2,1'b0,5'd0,1'b0,5'd0,32'h108,1'b0,1'b0,8'd6},  // R6 not taken
    '{2'd1,1'b1,1'b1,32'd1,32'd2,NEG2, 5'd1,5'd2,1'b0,5'd0,1'b0,5'd0,32'h0FC,1'b1,1'b0,8'd2},  // R2 bne backward
    '{2'd1,1'b1,1'b0,32'd5,32'd5,32'd4,5'd1,5'd2,1'b1,5'd2,1'b0,5'd0,32'h104,1'b0,1'b1,8'd7},  // R7 ex hit
    '{2'd3,1'b1,1'b0,32'd5,32'd5,32'd4,5'd1,5'd2,1'b0,5'd0,1'b1,5'd1,32'h104,1'b0,1'b1,8'd8},  // R8 load hit
    '{2'd1,1'b1,1'b0,32'd5,32'd5,32'd4,5'd0,5'd0,1'b1,5'd0,1'b1,5'd0,32'h114,1'b1,1'b0,8'd9},  // R9 r0 writer
    '{2'd0,1'b0,1'b0,32'd5,32'd5,32'd4,5'd1,5'd2,1'b1,5'd1,1'b0,5'd0,32'h108,1'b0,1'b0,8'd1},  // R1 no branch
    '{2'd2,1'b1,1'b0,32'd5,32'd6,32'd4,5'd1,5'd2,1'b1,5'd3,1'b1,5'd2,32'h104,1'b0,1'b1,8'd8}   // R8 load on rt
  };

  task automatic check(input string tag, input logic [31:0] enpc,
                       input logic efl, input logic ehd);
    n_chk++;
    if (next_pc !== enpc || ifid_flush !== efl || fetch_hold !== ehd) begin
      n_fail++;
      $display("FAIL %s: next_pc=%h flush=%b hold=%b expected next_pc=%h flush=%b hold=%b",
               tag, next_pc, ifid_flush, fetch_hold, enpc, efl, ehd);
    end
  endtask

  task automatic idle();
    id_branch = 1'b0; id_br_ne = 1'b0; ex_wr_en = 1'b0; mem_ld = 1'b0;
    id_rs = 5'd1; id_rt = 5'd2; ex_rd = 5'd0; mem_rd = 5'd0;
    rs_val = '0; rt_val = '0; imm_ext = 32'd4;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; policy_sel = 2'd0; id_pc = 32'h100; if_pc = 32'h104;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 32'h108, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      idle();
      policy_sel = VEC[i].pol;
      @(posedge clk); #1;
      id_branch = VEC[i].br; id_br_ne = VEC[i].ne;
      rs_val = VEC[i].a; rt_val = VEC[i].b; imm_ext = VEC[i].off;
      id_rs = VEC[i].rs; id_rt = VEC[i].rt;
      ex_wr_en = VEC[i].exw; ex_rd = VEC[i].exd;
      mem_ld = VEC[i].mld; mem_rd = VEC[i].mdd;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].npc, VEC[i].fl, VEC[i].hd);
      @(posedge clk); #1;
    end

    // R10: policy frozen while a branch sits in decode
    idle(); policy_sel = 2'd3;
    @(posedge clk); #1;
    id_branch = 1'b1; rs_val = 32'd5; rt_val = 32'd6;
    ex_wr_en = 1'b1; ex_rd = 5'd1; policy_sel = 2'd0;
    @(negedge clk);
    check("R10 held branch", 32'h104, 1'b0, 1'b1);
    @(posedge clk); #1;
    ex_wr_en = 1'b0;
    @(negedge clk);
    check("R10 old policy kept", 32'h108, 1'b0, 1'b0);
    @(posedge clk); #1;
    idle(); policy_sel = 2'd0;
    @(negedge clk);
    check("R10 idle between", 32'h108, 1'b0, 1'b0);
    @(posedge clk); #1;
    id_branch = 1'b1; rs_val = 32'd5; rt_val = 32'd6;
    @(negedge clk);
    check("R10 new policy active", 32'h104, 1'b1, 1'b0);
    @(posedge clk); #1;
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule